// File: doc/BRIEF.md
# Mapping entry loader and decoder

This block fetches a three-byte mapping entry for a chosen game slot from a hidden sector of the cartridge flash and turns it into the fields the bank mapper needs. It runs once on its own after power-up (slot 0, with the host held in reset) and again whenever a start pulse arrives with a new slot number. It drives a private memory bus. On that bus it first sends a fixed command sequence that exposes the hidden sector, then reads two filler bytes and the three entry bytes, and last sends a command that returns the flash to normal reads.

A mode flag given with the start pulse chooses how the host reset behaves. In reset mode the host reset is held low for the whole fetch and released when the last command completes. In no-reset mode the host reset is never touched. While the loader is busy, host requests to the mapper are held back. The decoded fields change only when a fetch completes, and all of them change together.

Top module: `map_entry_loader`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `host_rst_n` is 0 and all decoded outputs are 0. After `rst_n` rises, the block fetches slot 0 in reset mode without a start pulse.
- R2: A fetch makes exactly 13 bus accesses, in this order:
  - a write of F0h to 0000h;
  - writes of AAh to 5555h, 55h to 2AAAh and 77h to 5555h;
  - the same three writes again;
  - two reads at the entry base (filler, discarded);
  - reads at base, base+1 and base+2;
  - a write of F0h to 0000h.
- R3: Each access is a one-cycle strobe (`mem_we` for a write, `mem_oe` for a read) on the first cycle of a slot of STEP_CYC cycles, and read data is taken in that same cycle. `busy` is high for 13*STEP_CYC cycles after the edge that samples `start`.
- R4: `map_type` is byte 0 bits 7..5 and `rom_size` is byte 0 bits 4..2.
- R5: `sram_type` is {byte 0 bits 1..0, byte 1 bit 7}.
- R6: `rom_base` is byte 1 bits 4..2 times 128 KB (a 20-bit byte offset).
- R7: `ram_base` is byte 2 bits 5..2 times 8 KB (a 17-bit byte offset).
- R8: In reset mode (`reset_mode`=1), `host_rst_n` goes low at the edge that samples `start` and rises at the edge where `busy` falls.
- R9: In no-reset mode (`reset_mode`=0), `host_rst_n` stays high for the whole fetch.
- R10: `map_req` follows `host_req` while idle and is 0 while `busy` is high. A `start` pulse that arrives while busy is ignored.
- R11: The decoded outputs keep their previous values during a fetch. All of them take the new values at the edge where `busy` falls.
- R12: The entry base address is the slot number times 3, for slot numbers 0 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to fetch an entry |
| slot | input | 6 | Slot number to fetch |
| reset_mode | input | 1 | 1 = hold host reset during the fetch |
| host_req | input | 1 | Host request toward the mapper |
| map_req | output | 1 | Request passed on to the mapper |
| busy | output | 1 | Fetch in progress |
| host_rst_n | output | 1 | Active-low reset to the host |
| mem_addr | output | 16 | Private bus address |
| mem_wdata | output | 8 | Private bus write data |
| mem_we | output | 1 | Write strobe |
| mem_oe | output | 1 | Read strobe |
| flash_rdata | input | 8 | Flash read data |
| map_type | output | 3 | Mapper type |
| rom_size | output | 3 | ROM size code |
| sram_type | output | 3 | SRAM code |
| rom_base | output | 20 | ROM base byte offset |
| ram_base | output | 17 | RAM base byte offset |

## Verification
- **Bus accesses:** one access is due every STEP_CYC cycles, starting one cycle after the edge that samples `start`. A scoreboard compares each strobe, at the falling clock edge, with the next expected access in the queue.
- **Busy and host reset:** the bench counts falling edges from the sampling edge until `busy` drops and expects exactly 13*STEP_CYC. It samples `host_rst_n` and `map_req` at every one of those edges.
- **Decoded fields:** these are checked after `busy` falls. They are also checked twenty cycles into a fetch, where they must still show the previous entry.

// File: rtl/maploader_pkg.sv
// Shared constants for the mapping entry loader.
// Assumes the fixed 13-access fetch sequence described in the brief.
package maploader_pkg;
    localparam int NUM_STEPS  = 13;
    localparam int STEP_W     = 4;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_UNLK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B = 8'h55;
    localparam logic [7:0] CMD_HIDDEN = 8'h77;
    localparam logic [15:0] ADR_UNLK_A = 16'h5555;
    localparam logic [15:0] ADR_UNLK_B = 16'h2AAA;
    // step indices where entry bytes are read
    localparam logic [STEP_W-1:0] ST_BYTE0 = 4'd9;
    localparam logic [STEP_W-1:0] ST_BYTE1 = 4'd10;
    localparam logic [STEP_W-1:0] ST_BYTE2 = 4'd11;
endpackage

// File: rtl/ml_seq_ctrl.sv
// Sequencer control: step and cycle counters, busy flag, latched slot and
// host reset. Starts a slot-0 fetch right after reset. Assumes STEP_CYC >= 2.
module ml_seq_ctrl
    import maploader_pkg::*;
#(
    parameter int STEP_CYC = 4,
    parameter int SLOT_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SLOT_W-1:0]   slot_in,
    input  logic                reset_mode,
    output logic                busy,
    output logic [STEP_W-1:0]   step,
    output logic                first_cyc,
    output logic                done,
    output logic [SLOT_W-1:0]   slot_q,
    output logic                host_rst_n
);
    localparam int CW = $clog2(STEP_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(STEP_CYC - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);

    logic [CW-1:0] cnt;
    logic          last_cyc;

    // cycle position decode within the current access slot
    always_comb begin
        first_cyc = busy && (cnt == '0);
        last_cyc  = busy && (cnt == CNT_LAST);
        done      = last_cyc && (step == STEP_LAST);
    end

    // advance counters, accept start while idle, drive host reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b1;
            step       <= '0;
            cnt        <= '0;
            slot_q     <= '0;
            host_rst_n <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy       <= 1'b1;
                step       <= '0;
                cnt        <= '0;
                slot_q     <= slot_in;
                host_rst_n <= !reset_mode;
            end
        end else if (last_cyc) begin
            cnt <= '0;
            if (done) begin
                busy       <= 1'b0;
                host_rst_n <= 1'b1;
            end else begin
                step <= step + 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ml_bus_gen.sv
// Translates the current step into one private-bus access. The strobe is
// asserted only on the first cycle of a step. Assumes the step order of the package.
module ml_bus_gen
    import maploader_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SLOT_W = 6
) (
    input  logic [STEP_W-1:0]  step,
    input  logic               busy,
    input  logic               first_cyc,
    input  logic [SLOT_W-1:0]  slot_q,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               mem_we,
    output logic               mem_oe
);
    logic [ADDR_W-1:0] base;
    logic              is_wr;
    logic              is_rd;

    // entry base address: slot * 3
    always_comb base = ADDR_W'(slot_q) + (ADDR_W'(slot_q) << 1);

    // step decode into address, data and access kind
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        is_wr     = 1'b0;
        is_rd     = 1'b0;
        case (step)
            4'd0, 4'd12: begin is_wr = 1'b1; mem_wdata = CMD_RESET; end
            4'd1, 4'd4:  begin is_wr = 1'b1; mem_wdata = CMD_UNLK_A;
                               mem_addr = ADDR_W'(ADR_UNLK_A); end
            4'd2, 4'd5:  begin is_wr = 1'b1; mem_wdata = CMD_UNLK_B;
                               mem_addr = ADDR_W'(ADR_UNLK_B); end
            4'd3, 4'd6:  begin is_wr = 1'b1; mem_wdata = CMD_HIDDEN;
                               mem_addr = ADDR_W'(ADR_UNLK_A); end
            4'd7, 4'd8, 4'd9: begin is_rd = 1'b1; mem_addr = base; end
            4'd10:       begin is_rd = 1'b1; mem_addr = base + ADDR_W'(1); end
            4'd11:       begin is_rd = 1'b1; mem_addr = base + ADDR_W'(2); end
            default:     ;
        endcase
        if (!busy) begin
            mem_addr  = '0;
            mem_wdata = '0;
        end
        mem_we = is_wr && first_cyc;
        mem_oe = is_rd && first_cyc;
    end
endmodule

// File: rtl/ml_entry_decode.sv
// Captures the needed fields of the three entry bytes and commits the decoded
// mapping at the end of a fetch. Assumes data is valid in the read-strobe cycle.
module ml_entry_decode
    import maploader_pkg::*;
#(
    parameter int ROM_BLK_LG  = 17,
    parameter int ROM_BLKS_LG = 3,
    parameter int RAM_BLK_LG  = 13,
    parameter int RAM_BLKS_LG = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [STEP_W-1:0]            step,
    input  logic                         first_cyc,
    input  logic                         done,
    input  logic [7:0]                   flash_rdata,
    output logic [2:0]                   map_type,
    output logic [2:0]                   rom_size,
    output logic [2:0]                   sram_type,
    output logic [ROM_BLK_LG+ROM_BLKS_LG-1:0] rom_base,
    output logic [RAM_BLK_LG+RAM_BLKS_LG-1:0] ram_base
);
    logic [7:0]             b0_q;
    logic                   sram_lo_q;
    logic [ROM_BLKS_LG-1:0] rom_blk_q;
    logic [RAM_BLKS_LG-1:0] ram_blk_q;

    // capture fields from the bytes as they are read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b0_q      <= '0;
            sram_lo_q <= 1'b0;
            rom_blk_q <= '0;
            ram_blk_q <= '0;
        end else if (first_cyc) begin
            if (step == ST_BYTE0) b0_q <= flash_rdata;
            if (step == ST_BYTE1) begin
                sram_lo_q <= flash_rdata[7];
                rom_blk_q <= flash_rdata[ROM_BLKS_LG+1:2];
            end
            if (step == ST_BYTE2) ram_blk_q <= flash_rdata[RAM_BLKS_LG+1:2];
        end
    end

    // commit all decoded fields together when the fetch ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_type  <= '0;
            rom_size  <= '0;
            sram_type <= '0;
            rom_base  <= '0;
            ram_base  <= '0;
        end else if (done) begin
            map_type  <= b0_q[7:5];
            rom_size  <= b0_q[4:2];
            sram_type <= {b0_q[1:0], sram_lo_q};
            rom_base  <= {rom_blk_q, {ROM_BLK_LG{1'b0}}};
            ram_base  <= {ram_blk_q, {RAM_BLK_LG{1'b0}}};
        end
    end
endmodule

// File: rtl/map_entry_loader.sv
// Top of the mapping entry loader: fetches a slot's entry from the hidden
// flash sector, decodes it and gates host requests while busy.
module map_entry_loader
    import maploader_pkg::*;
#(
    parameter int STEP_CYC    = 4,
    parameter int SLOT_W      = 6,
    parameter int ADDR_W      = 16,
    parameter int ROM_BLK_LG  = 17,
    parameter int ROM_BLKS_LG = 3,
    parameter int RAM_BLK_LG  = 13,
    parameter int RAM_BLKS_LG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SLOT_W-1:0] slot,
    input  logic              reset_mode,
    input  logic              host_req,
    output logic              map_req,
    output logic              busy,
    output logic              host_rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_oe,
    input  logic [7:0]        flash_rdata,
    output logic [2:0]        map_type,
    output logic [2:0]        rom_size,
    output logic [2:0]        sram_type,
    output logic [ROM_BLK_LG+ROM_BLKS_LG-1:0] rom_base,
    output logic [RAM_BLK_LG+RAM_BLKS_LG-1:0] ram_base
);
    logic [STEP_W-1:0] step;
    logic              first_cyc;
    logic              done;
    logic [SLOT_W-1:0] slot_q;

    // host requests reach the mapper only while idle
    always_comb map_req = host_req && !busy;

    ml_seq_ctrl #(.STEP_CYC(STEP_CYC), .SLOT_W(SLOT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .slot_in(slot),
        .reset_mode(reset_mode), .busy(busy), .step(step),
        .first_cyc(first_cyc), .done(done), .slot_q(slot_q),
        .host_rst_n(host_rst_n)
    );

    ml_bus_gen #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_bus (
        .step(step), .busy(busy), .first_cyc(first_cyc), .slot_q(slot_q),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_oe(mem_oe)
    );

    ml_entry_decode #(
        .ROM_BLK_LG(ROM_BLK_LG), .ROM_BLKS_LG(ROM_BLKS_LG),
        .RAM_BLK_LG(RAM_BLK_LG), .RAM_BLKS_LG(RAM_BLKS_LG)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .step(step), .first_cyc(first_cyc),
        .done(done), .flash_rdata(flash_rdata), .map_type(map_type),
        .rom_size(rom_size), .sram_type(sram_type),
        .rom_base(rom_base), .ram_base(ram_base)
    );
endmodule

// File: rtl/ml_checker.sv
// Protocol checks for map_entry_loader, attached with bind.
module ml_checker #(
    parameter int RB_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            host_rst_n,
    input logic            host_req,
    input logic            map_req,
    input logic            mem_we,
    input logic            mem_oe,
    input logic [2:0]      map_type,
    input logic [RB_W-1:0] rom_base
);
    // R8 / R9: host reset is never held once the loader is idle
    a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> host_rst_n);

    // R10: host requests blocked while busy
    a_r10_req_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_req) |-> !map_req);

    // R10: a start during a fetch does not end it
    a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> busy);

    // R3: strobes only during a fetch and never both at once
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_oe) |-> (busy && !(mem_we && mem_oe)));

    // R11: decoded outputs hold while a fetch continues
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(map_type) && $stable(rom_base)));
endmodule

bind map_entry_loader ml_checker #(.RB_W(ROM_BLK_LG + ROM_BLKS_LG)) u_ml_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .host_rst_n(host_rst_n), .host_req(host_req), .map_req(map_req),
    .mem_we(mem_we), .mem_oe(mem_oe), .map_type(map_type), .rom_base(rom_base)
);

// File: tb/tb_map_entry_loader.sv
`timescale 1ns/1ps
module tb_map_entry_loader;
    localparam int STEP_CYC = 4;
    localparam int FETCH_CYC = 13 * STEP_CYC;

    logic        clk = 1'b0;
    logic        rst_n, start, reset_mode, host_req;
    logic [5:0]  slot;
    logic        map_req, busy, host_rst_n, mem_we, mem_oe;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, flash_rdata;
    logic [2:0]  map_type, rom_size, sram_type;
    logic [19:0] rom_base;
    logic [16:0] ram_base;

    int total = 0;
    int bad = 0;
    logic [24:0] exp_q[$];   // {we, addr, data}

    always #2.5 clk = ~clk;

    map_entry_loader #(.STEP_CYC(STEP_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .slot(slot),
        .reset_mode(reset_mode), .host_req(host_req), .map_req(map_req),
        .busy(busy), .host_rst_n(host_rst_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_oe(mem_oe),
        .flash_rdata(flash_rdata), .map_type(map_type), .rom_size(rom_size),
        .sram_type(sram_type), .rom_base(rom_base), .ram_base(ram_base)
    );

    // hidden sector content, computed per address
    function automatic logic [7:0] hid_byte(input int a);
        int s = a / 3;
        int k = a % 3;
        if (k == 0) return 8'((s * 37 + 8'h29) & 255);
        if (k == 1) return 8'((s * 91 + 8'h13) & 255);
        return 8'((s * 13 + 7) & 255);
    endfunction

    assign flash_rdata = (mem_oe && mem_addr < 16'd192) ? hid_byte(int'(mem_addr)) : 8'h00;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver side: queue the 13 accesses of a fetch (R2, R12)
    task automatic push_fetch(input int s);
        logic [15:0] b = 16'(s * 3);
        exp_q.push_back({1'b1, 16'h0000, 8'hF0});
        for (int r = 0; r < 2; r++) begin
            exp_q.push_back({1'b1, 16'h5555, 8'hAA});
            exp_q.push_back({1'b1, 16'h2AAA, 8'h55});
            exp_q.push_back({1'b1, 16'h5555, 8'h77});
        end
        exp_q.push_back({1'b0, b, 8'h00});
        exp_q.push_back({1'b0, b, 8'h00});
        exp_q.push_back({1'b0, b, 8'h00});
        exp_q.push_back({1'b0, b + 16'd1, 8'h00});
        exp_q.push_back({1'b0, b + 16'd2, 8'h00});
        exp_q.push_back({1'b1, 16'h0000, 8'hF0});
    endtask

    // monitor: compare each strobe with the scoreboard (R2, R3)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && (mem_we || mem_oe)) begin
            logic [24:0] e;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected access", {mem_we, mem_addr}, 0);
            end else begin
                e = exp_q.pop_front();
                chk(mem_we == e[24] && mem_oe == !e[24] && mem_addr == e[23:8],
                    "R2 access kind/addr", {mem_we, mem_addr}, e[24:8]);
                if (e[24]) chk(mem_wdata == e[7:0], "R2 write data", mem_wdata, e[7:0]);
            end
        end
    end

    // decoded fields expected for a slot (R4..R7)
    task automatic check_decode(input int s, input string when);
        logic [7:0] b0 = hid_byte(s * 3);
        logic [7:0] b1 = hid_byte(s * 3 + 1);
        logic [7:0] b2 = hid_byte(s * 3 + 2);
        chk(map_type == b0[7:5], {"R4 map_type ", when}, map_type, b0[7:5]);
        chk(rom_size == b0[4:2], {"R4 rom_size ", when}, rom_size, b0[4:2]);
        chk(sram_type == {b0[1:0], b1[7]}, {"R5 sram_type ", when}, sram_type, {b0[1:0], b1[7]});
        chk(rom_base == 20'(int'(b1[4:2]) * 131072), {"R6 rom_base ", when}, rom_base,
            20'(int'(b1[4:2]) * 131072));
        chk(ram_base == 17'(int'(b2[5:2]) * 8192), {"R7 ram_base ", when}, ram_base,
            17'(int'(b2[5:2]) * 8192));
    endtask

    // one fetch with timing, reset, gating and hold checks
    task automatic run_fetch(input int s, input bit mode, input int prev, input bit interfere);
        int n = 0;
        int rst_bad = 0;
        int req_bad = 0;
        host_req = 1'b1;
        @(negedge clk);
        chk(map_req == 1'b1, "R10 idle pass-through", map_req, 1);
        push_fetch(s);
        slot = 6'(s);
        reset_mode = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3 busy after start", busy, 1);
        while (busy) begin
            n++;
            if (host_rst_n != !mode) rst_bad++;
            if (map_req) req_bad++;
            if (n == 10 && interfere) begin
                slot = 6'((s + 7) & 63);
                reset_mode = !mode;
                start = 1'b1;
            end
            if (n == 11) start = 1'b0;
            if (n == 20) check_decode(prev, "R11 hold mid-fetch");
            if (n > FETCH_CYC + 20) break;
            @(negedge clk);
        end
        chk(n == FETCH_CYC, "R3 busy length", n, FETCH_CYC);
        if (mode) chk(rst_bad == 0, "R8 host reset held", rst_bad, 0);
        else      chk(rst_bad == 0, "R9 host reset untouched", rst_bad, 0);
        chk(req_bad == 0, "R10 requests blocked", req_bad, 0);
        chk(host_rst_n == 1'b1, "R8 reset released at end", host_rst_n, 1);
        chk(exp_q.size() == 0, "R2 all accesses seen", exp_q.size(), 0);
        check_decode(s, "after fetch R11");
        if (interfere) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b0, "R10 start while busy ignored", busy, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; slot = '0; reset_mode = 1'b0; host_req = 1'b0;
        push_fetch(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        chk(host_rst_n == 1'b0, "R1 host reset in reset", host_rst_n, 0);
        chk({map_type, rom_size, sram_type} == '0 && rom_base == '0 && ram_base == '0,
            "R1 outputs zero", {map_type, rom_size, sram_type}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 2 * FETCH_CYC && busy; i++) @(negedge clk);
        chk(busy == 1'b0, "R1 power-up fetch ends", busy, 0);
        chk(host_rst_n == 1'b1, "R1 host released", host_rst_n, 1);
        chk(exp_q.size() == 0, "R1 power-up accesses", exp_q.size(), 0);
        check_decode(0, "R1 power-up");
        run_fetch(5, 1'b1, 0, 1'b0);
        run_fetch(63, 1'b0, 5, 1'b0);   // R12 top slot
        run_fetch(1, 1'b1, 63, 1'b1);   // R10 start during fetch
        run_fetch(42, 1'b0, 1, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule